// File: doc/BRIEF.md
# Parallel Codeword Stream Joiner

This block sits behind a set of residual-coding encoder units that work side by side: the unit that produces the coefficient-count token, the unit for the signs of the trailing unit-magnitude coefficients, the level unit, the total-zeros unit and the zero-run unit. Each unit hands over codewords as a value plus a bit length, whenever it has one, and with no ordering relative to the other units. Every unit's codewords are packed into a private per-unit bit buffer. The sign bits or escape fields that an encoder wants directly behind a codeword are presented as further codewords on the same lane, so they land right after it.

When the block-end strobe is accepted, the block stops taking input and links the five private buffers into a single stream. The fixed order is count token, trailing signs, levels, total zeros, zero runs. Bits enter a 32-bit accumulator most significant bit first. Every time the accumulator fills, the full word goes out on a valid/ready port toward an output FIFO. Bits that do not fill a word at the end of a block stay in the accumulator and lead the next block's stream, with no padding. While the output port is stalled, or while a block is being linked, a single ready line holds off all inputs.

Top module: `vlc_concat`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: An accepted codeword on lane u adds exactly its low cw_len bits to the stream, highest of those bits first. Value bits above the length are ignored, and a length of 0 adds nothing.
- R3: Codewords accepted on the same lane appear back to back in the stream in the order they were accepted.
- R4: Within a block, the lane streams are joined in lane order 0,1,2,3,4 (count token, trailing signs, levels, total zeros, zero runs), whatever order the codewords arrived in.
- R5: No word of a block leaves before that block's block-end strobe is accepted. A new output word only follows a cycle in which in_ready was 0.
- R6: The first stream bit goes to bit 31 of the first output word, and later bits fill downward toward bit 0 and then into the next word.
- R7: At the end of a block, any remainder of fewer than 32 bits is kept and heads the next block. After linking, the number of words sent equals the total stream length divided by 32, rounded down.
- R8: in_ready is 0 in the cycle after a block-end strobe is accepted, and it stays 0 until linking is done. It is also 0 while out_valid is 1 and out_ready is 0.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid | input | 5 | Per-lane codeword strobe, bit u for lane u |
| cw_value | input | 5*CW_W | Per-lane codeword values, lane u in bits [u*CW_W +: CW_W] |
| cw_len | input | 5*LEN_W | Per-lane codeword lengths, lane u in bits [u*LEN_W +: LEN_W] |
| blk_end | input | 1 | Block finished; accepted together with any codewords in the same cycle |
| in_ready | output | 1 | Inputs are accepted in a cycle where this is 1 |
| out_valid | output | 1 | out_data holds a complete word |
| out_data | output | WORD_W | Packed output word, first bit in the MSB |
| out_ready | input | 1 | Downstream FIFO can take the word |

## Verification
The bench uses the default parameters: 16-bit codewords, a 32-bit output word and 128-bit per-lane buffers. With these settings a single codeword can straddle two output words, and one block can carry more than two words of stream. Five simultaneous 16-bit codewords push the leftover remainder across several word boundaries. A stalled output during linking shows both the held word and the blocked input at the same time.

// File: rtl/vlc_cat_pkg.sv
package vlc_cat_pkg;
  localparam int N_UNITS = 5;
  localparam int UIDX_W  = 3;

  // Lane index doubles as the join order of the stream.
  typedef enum logic [UIDX_W-1:0] {
    U_COEFF_TOKEN = 3'd0,
    U_T1_SIGNS    = 3'd1,
    U_LEVELS      = 3'd2,
    U_TOTAL_ZEROS = 3'd3,
    U_RUN_BEFORE  = 3'd4
  } unit_e;

  typedef enum logic {
    PH_COLLECT = 1'b0,
    PH_LINK    = 1'b1
  } phase_e;
endpackage

// File: rtl/vlc_cat_unit.sv
// One lane's private bit buffer: appends codewords, hands out its oldest bits.
module vlc_cat_unit #(
  parameter int CW_W      = 16,
  parameter int WORD_W    = 32,
  parameter int UNIT_BITS = 128,
  localparam int LEN_W    = $clog2(CW_W + 1),
  localparam int FILL_W   = $clog2(UNIT_BITS + 1),
  localparam int WCNT_W   = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_en,
  input  logic [CW_W-1:0]   app_value,
  input  logic [LEN_W-1:0]  app_len,
  input  logic              take_en,
  input  logic [WCNT_W-1:0] take_len,
  output logic [FILL_W-1:0] fill,
  output logic [WORD_W-1:0] peek
);
  logic [UNIT_BITS-1:0] bits_q, bits_d;
  logic [FILL_W-1:0]    fill_q, fill_d;
  logic [CW_W-1:0]      lane_mask;
  logic [UNIT_BITS-1:0] field;
  logic [UNIT_BITS-1:0] shifted;
  logic                 upd_en;

  always_comb begin
    lane_mask = ~({CW_W{1'b1}} << app_len);
    field     = UNIT_BITS'(app_value & lane_mask);
    bits_d    = bits_q;
    fill_d    = fill_q;
    if (app_en) begin
      bits_d = (bits_q << app_len) | field;
      fill_d = fill_q + FILL_W'(app_len);
    end else if (take_en) begin
      fill_d = fill_q - FILL_W'(take_len);
    end
    upd_en  = app_en | take_en;
    // Oldest take_len bits end up right-aligned; the link stage masks the rest.
    shifted = bits_q >> (fill_q - FILL_W'(take_len));
    peek    = shifted[WORD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      fill_q <= '0;
    end else if (upd_en) begin
      bits_q <= bits_d;
      fill_q <= fill_d;
    end
  end

  assign fill = fill_q;
endmodule

// File: rtl/vlc_cat_link.sv
// Output accumulator: gathers segments MSB-first and emits full words.
module vlc_cat_link #(
  parameter int WORD_W  = 32,
  localparam int WCNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_en,
  input  logic [WORD_W-1:0] seg,
  input  logic [WCNT_W-1:0] seg_len,
  input  logic              out_ready,
  output logic              room,
  output logic [WCNT_W-1:0] acc_fill,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WCNT_W-1:0] fill_q, fill_d;
  logic              ov_q, ov_d;
  logic [WORD_W-1:0] od_q, od_d;
  logic [WORD_W-1:0] seg_mask;
  logic [WORD_W-1:0] merged;
  logic [WCNT_W-1:0] sum;
  logic              acc_en;
  logic              od_en;

  always_comb begin
    room     = !ov_q || out_ready;
    seg_mask = ~({WORD_W{1'b1}} << seg_len);
    merged   = (acc_q << seg_len) | (seg & seg_mask);
    sum      = fill_q + seg_len;
    acc_d    = acc_q;
    fill_d   = fill_q;
    ov_d     = ov_q && !out_ready;
    od_d     = od_q;
    acc_en   = 1'b0;
    od_en    = 1'b0;
    if (seg_en) begin
      if (sum == WCNT_W'(WORD_W)) begin
        od_d   = merged;
        od_en  = 1'b1;
        ov_d   = 1'b1;
        fill_d = '0;
      end else begin
        acc_d  = merged;
        acc_en = 1'b1;
        fill_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (od_en)  od_q  <= od_d;
      fill_q <= fill_d;
      ov_q   <= ov_d;
    end
  end

  assign acc_fill  = fill_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/vlc_concat.sv
module vlc_concat
  import vlc_cat_pkg::*;
#(
  parameter int CW_W      = 16,
  parameter int WORD_W    = 32,
  parameter int UNIT_BITS = 128,
  localparam int LEN_W    = $clog2(CW_W + 1),
  localparam int FILL_W   = $clog2(UNIT_BITS + 1),
  localparam int WCNT_W   = $clog2(WORD_W + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_UNITS-1:0]         cw_valid,
  input  logic [N_UNITS*CW_W-1:0]    cw_value,
  input  logic [N_UNITS*LEN_W-1:0]   cw_len,
  input  logic                       blk_end,
  output logic                       in_ready,
  output logic                       out_valid,
  output logic [WORD_W-1:0]          out_data,
  input  logic                       out_ready
);
  phase_e             phase_q, phase_d;
  logic [UIDX_W-1:0]  cur_q, cur_d;
  logic               room;
  logic [WCNT_W-1:0]  acc_fill;
  logic               accept;
  logic               link_go;
  logic [FILL_W-1:0]  fills [N_UNITS];
  logic [WORD_W-1:0]  peeks [N_UNITS];
  logic [FILL_W-1:0]  sel_fill;
  logic [WORD_W-1:0]  sel_peek;
  logic [WCNT_W-1:0]  space;
  logic [WCNT_W-1:0]  take;
  logic               unit_done;

  assign accept   = (phase_q == PH_COLLECT) && room;
  assign in_ready = accept;
  assign link_go  = (phase_q == PH_LINK) && room;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    vlc_cat_unit #(
      .CW_W(CW_W), .WORD_W(WORD_W), .UNIT_BITS(UNIT_BITS)
    ) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .app_en   (accept && cw_valid[u]),
      .app_value(cw_value[u*CW_W +: CW_W]),
      .app_len  (cw_len[u*LEN_W +: LEN_W]),
      .take_en  (link_go && (cur_q == UIDX_W'(u))),
      .take_len (take),
      .fill     (fills[u]),
      .peek     (peeks[u])
    );
  end

  always_comb begin
    sel_fill = '0;
    sel_peek = '0;
    for (int u = 0; u < N_UNITS; u++) begin
      if (cur_q == UIDX_W'(u)) begin
        sel_fill = fills[u];
        sel_peek = peeks[u];
      end
    end
    space     = WCNT_W'(WORD_W) - acc_fill;
    take      = (sel_fill < FILL_W'(space)) ? WCNT_W'(sel_fill) : space;
    unit_done = (FILL_W'(take) == sel_fill);
  end

  vlc_cat_link #(.WORD_W(WORD_W)) u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .seg_en   (link_go),
    .seg      (sel_peek),
    .seg_len  (take),
    .out_ready(out_ready),
    .room     (room),
    .acc_fill (acc_fill),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  always_comb begin
    phase_d = phase_q;
    cur_d   = cur_q;
    if (accept && blk_end) begin
      phase_d = PH_LINK;
      cur_d   = UIDX_W'(U_COEFF_TOKEN);
    end else if (link_go && unit_done) begin
      if (cur_q == UIDX_W'(U_RUN_BEFORE)) phase_d = PH_COLLECT;
      else                                cur_d   = cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_COLLECT;
      cur_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cur_q   <= cur_d;
    end
  end
endmodule

// File: rtl/vlc_cat_chk.sv
module vlc_cat_chk #(
  parameter int WORD_W = 32,
  parameter int WCNT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_end,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [WCNT_W-1:0] acc_fill
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!out_valid);
    end
  end

  p_word_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !$past(in_ready));

  p_carry_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fill < WCNT_W'(WORD_W));

  p_link_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && blk_end) |=> !in_ready);

  p_hold_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind vlc_concat vlc_cat_chk #(.WORD_W(WORD_W), .WCNT_W(WCNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .blk_end  (blk_end),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .acc_fill (acc_fill)
);

// File: tb/vlc_concat_test.sv
`timescale 1ns/1ps
module vlc_concat_test;
  localparam int NU = 5;
  localparam int CW = 16;
  localparam int LW = 5;
  localparam int NV = 16;

  // {end, lane[2:0], len[4:0], value[15:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 3'd4, 5'd3,  16'h0005},   // R4 late lane arrives first
    {1'b0, 3'd2, 5'd7,  16'h07F3},   // R2 garbage above length
    {1'b0, 3'd0, 5'd5,  16'h0003},
    {1'b0, 3'd1, 5'd2,  16'h0002},
    {1'b0, 3'd3, 5'd4,  16'h0009},
    {1'b0, 3'd2, 5'd13, 16'h1ABC},   // R3 second on same lane
    {1'b0, 3'd0, 5'd0,  16'hFFFF},   // R2 zero length
    {1'b1, 3'd2, 5'd16, 16'hBEEF},
    {1'b0, 3'd1, 5'd1,  16'h0001},
    {1'b0, 3'd3, 5'd9,  16'h01F0},
    {1'b1, 3'd0, 5'd11, 16'h0555},
    {1'b0, 3'd2, 5'd16, 16'h1234},
    {1'b0, 3'd2, 5'd16, 16'h5678},
    {1'b0, 3'd4, 5'd6,  16'h002A},
    {1'b0, 3'd0, 5'd16, 16'hFFFF},
    {1'b1, 3'd3, 5'd8,  16'h0081}
  };

  logic              clk;
  logic              rst_n;
  logic [NU-1:0]     cw_valid;
  logic [NU*CW-1:0]  cw_value;
  logic [NU*LW-1:0]  cw_len;
  logic              blk_end;
  logic              in_ready;
  logic              out_valid;
  logic [31:0]       out_data;
  logic              out_ready;

  int n_tests, n_fail, words_seen, es_wr, es_rd;
  bit ub [NU][256];
  int uf [NU];
  bit es [8192];
  bit done_flag;

  vlc_concat uut (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_value(cw_value),
    .cw_len(cw_len), .blk_end(blk_end), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Monitor: a word transfers at the next edge when valid and ready at negedge.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      logic [31:0] exp;
      exp = '0;
      for (int i = 0; i < 32; i++) exp[31-i] = es[es_rd + i];
      if (es_rd + 32 > es_wr)
        check(1'b0, "R5", "word before block end", out_data, 32'h0);
      else
        check(out_data == exp, "R2 R3 R4 R6", "stream word", out_data, exp);
      es_rd += 32;
      words_seen++;
    end
  end

  task automatic issue(input logic [NU-1:0] vm, input logic [NU*CW-1:0] vals,
                       input logic [NU*LW-1:0] lens, input logic endf);
    @(posedge clk); #1;
    cw_valid = vm; cw_value = vals; cw_len = lens; blk_end = endf;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int u = 0; u < NU; u++) begin
      if (vm[u]) begin
        for (int b = int'(lens[u*LW +: LW]) - 1; b >= 0; b--) begin
          ub[u][uf[u]] = vals[u*CW + b];
          uf[u]++;
        end
      end
    end
    if (endf) begin
      for (int u = 0; u < NU; u++) begin
        for (int i = 0; i < uf[u]; i++) begin
          es[es_wr] = ub[u][i];
          es_wr++;
        end
        uf[u] = 0;
      end
    end
    @(posedge clk); #1;
    cw_valid = '0; blk_end = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (in_ready) break;
    end
  endtask

  initial begin
    #1000000;
    check(1'b0, "R8", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] held;
    n_tests = 0; n_fail = 0; words_seen = 0; es_wr = 0; es_rd = 0;
    done_flag = 1'b0;
    for (int u = 0; u < NU; u++) uf[u] = 0;
    cw_valid = '0; cw_value = '0; cw_len = '0; blk_end = 1'b0; out_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'h1);

    // Table walk: three blocks with lanes arriving out of syntax order.
    for (int v = 0; v < NV; v++) begin
      logic [NU-1:0]    vm;
      logic [NU*CW-1:0] vals;
      logic [NU*LW-1:0] lens;
      int               lane;
      lane = int'(VEC[v][23:21]);
      vm = '0; vals = '0; lens = '0;
      vm[lane] = 1'b1;
      vals[lane*CW +: CW] = VEC[v][15:0];
      lens[lane*LW +: LW] = VEC[v][20:16];
      issue(vm, vals, lens, VEC[v][24]);
      if (VEC[v][24]) begin
        check(in_ready == 1'b0, "R8", "in_ready while linking", 32'(in_ready), 32'h0);
        wait_idle();
        check(words_seen == es_wr / 32, "R7", "words after block", words_seen, es_wr / 32);
      end else if (v < 7) begin
        check(out_valid == 1'b0, "R5", "no word before block end", 32'(out_valid), 32'h0);
      end
    end

    // All lanes in one cycle together with the block end.
    issue(5'b11111, {16'hA5C3, 16'h0F0F, 16'h8001, 16'h7FFE, 16'hC0DE},
          {5'd16, 5'd16, 5'd16, 5'd16, 5'd16}, 1'b1);
    wait_idle();
    check(words_seen == es_wr / 32, "R7", "words after full-lane block", words_seen, es_wr / 32);

    // Stalled output: word held, inputs blocked.
    @(posedge clk); #1; out_ready = 1'b0;
    issue(5'b10101, {16'h1111, 16'h0000, 16'h2222, 16'h0000, 16'h3333},
          {5'd16, 5'd0, 5'd16, 5'd0, 5'd16}, 1'b1);
    repeat (20) @(negedge clk);
    check(out_valid == 1'b1, "R9", "word pending under stall", 32'(out_valid), 32'h1);
    check(in_ready == 1'b0, "R8", "in_ready under stall", 32'(in_ready), 32'h0);
    held = out_data;
    repeat (5) @(negedge clk);
    check(out_data == held, "R9", "word stable under stall", out_data, held);
    check(out_valid == 1'b1, "R9", "valid held under stall", 32'(out_valid), 32'h1);
    @(posedge clk); #1; out_ready = 1'b1;
    wait_idle();
    check(words_seen == es_wr / 32, "R7", "words after stalled block", words_seen, es_wr / 32);
    check((es_wr - words_seen * 32) < 32, "R7", "leftover below a word",
          es_wr - words_seen * 32, 32'd31);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule